// File: doc/BRIEF.md
# Locked Indexed Configuration Register File

This block is a bank of 256 byte-wide configuration registers that a processor reaches through two I/O ports: an index port that selects a register and a data port that reads or writes the selected one. All 256 bytes are driven out continuously on a flat vector, so that neighbouring logic can decode the fields it needs.

Writes are guarded by a lock register. Only the lock register itself can be written until it holds a magic key value. Once the key is present, each register takes a written value through its own writable-bit mask and then has its forced-one bits set. Reads return the stored byte, with two exceptions. One index returns a byte taken from an external real-time-clock index input. When a CPU-type input is set, a small group of indices reads as all ones, which keeps them clear of the processor's own registers.

Top module: `lockedCfgRegs`

## Requirements
- R1: A write to port 0x22 loads the 8-bit index. A read or write of port 0x23 then acts on the register the index selects. The index stays in place across data-port accesses.
- R2: The lock register is index 0x03 and is always writable. A write to any other index takes effect only while the lock register holds 0xC5. Writing a different value to the lock register locks the bank again.
- R3: Some indices store only part of the written byte, as `value AND mask`: 0x14→0xBF, 0x15→0xF1, 0x1C→0x1F, 0x1E→0x40, 0x22→0xFD, 0x28→0x3F, 0x36→0xE5, 0x37→0xEF, 0x3D→0x07, 0x40→0x3F.
- R4: Index 0x21 stores `(value AND 0xBB) OR 0x04`. Index 0x2B stores `(value AND 0xBF) OR 0x40`.
- R5: While `cpuAlt` is 1, a data-port read of index 0x20, or of any index 0xC0 or above, returns 0xFF. While `cpuAlt` is 0, these indices read their stored value.
- R6: A data-port read of index 0x3F returns `rtcIdx` rather than the stored byte. The stored byte still appears on `regFlat`.
- R7: After reset the registers hold 0x02=0x0F, 0x10=0xF1, 0x11=0xFF, 0x15=0x20, 0x16=0x30, 0x19=0x04, 0x3C=0x03, 0x3D=0x01, 0x40=0x03, and every other register holds 0x00. The bank therefore starts locked.
- R8: `ioRdata` is 0xFF whenever `ioRd` is low or `ioAddr` is not the data port.
- R9: Indices not named in R3 or R4 store all eight written bits. Register n appears on `regFlat[8n+7:8n]`. A write becomes visible on the first clock edge where `ioWr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Write strobe, sampled at the clock edge |
| ioRd | input | 1 | Read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, combinational |
| cpuAlt | input | 1 | CPU-type select; hides some indices from reads |
| rtcIdx | input | 8 | External RTC index byte, returned for index 0x3F |
| regFlat | output | 2048 | All registers, byte n at bits 8n+7:8n |

## Verification
A wrong index register shows up at the ports straight away: the next data-port read or write lands on the wrong byte of `regFlat`. A broken lock comparison shows up one edge after any write made while locked, as a changed byte that should have held its value. Mask and forced-bit faults only appear in the byte written, one edge after the write. For that reason every index is written with several patterns, and both `regFlat` and the read path are compared after each write.

// File: rtl/cfgPkg.sv
package cfgPkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic idxLoad;
    logic regWrite;
    logic dataRead;
  } cfgStrobes_t;

  function automatic logic [7:0] maskOf(input int idx);
    case (idx)
      'h14: maskOf = 8'hBF;
      'h15: maskOf = 8'hF1;
      'h1C: maskOf = 8'h1F;
      'h1E: maskOf = 8'h40;
      'h21: maskOf = 8'hBB;
      'h22: maskOf = 8'hFD;
      'h28: maskOf = 8'h3F;
      'h2B: maskOf = 8'hBF;
      'h36: maskOf = 8'hE5;
      'h37: maskOf = 8'hEF;
      'h3D: maskOf = 8'h07;
      'h40: maskOf = 8'h3F;
      default: maskOf = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] forceOf(input int idx);
    case (idx)
      'h21: forceOf = 8'h04;
      'h2B: forceOf = 8'h40;
      default: forceOf = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] resetOf(input int idx);
    case (idx)
      'h02: resetOf = 8'h0F;
      'h10: resetOf = 8'hF1;
      'h11: resetOf = 8'hFF;
      'h15: resetOf = 8'h20;
      'h16: resetOf = 8'h30;
      'h19: resetOf = 8'h04;
      'h3C: resetOf = 8'h03;
      'h3D: resetOf = 8'h01;
      'h40: resetOf = 8'h03;
      default: resetOf = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023,
  parameter logic [IDX_W-1:0] LOCK_IDX = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [BYTE_W-1:0] ioWdata,
  input  logic              unlocked,
  output logic [IDX_W-1:0]  curIdx,
  output cfgStrobes_t       stb
);
  logic hitIndex;
  logic hitData;

  assign hitIndex = (ioAddr == INDEX_PORT);
  assign hitData  = (ioAddr == DATA_PORT);

  always_comb begin
    stb.idxLoad  = ioWr && hitIndex;
    stb.regWrite = ioWr && hitData && ((curIdx == LOCK_IDX) || unlocked);
    stb.dataRead = ioRd && hitData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) curIdx <= '0;
    else if (stb.idxLoad) curIdx <= ioWdata[IDX_W-1:0];
  end

  // R1: an index-port write is the index seen on the next cycle
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == INDEX_PORT) |=> (curIdx == $past(ioWdata[IDX_W-1:0])));

  // R2: while locked, only the lock index may produce a register write
  a_r2_locked_gate: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWrite && !unlocked) |-> (curIdx == LOCK_IDX));
endmodule

// File: rtl/cfgStore.sv
module cfgStore
  import cfgPkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] LOCK_IDX = 8'h03,
  parameter logic [BYTE_W-1:0] UNLOCK_KEY = 8'hC5,
  parameter logic [IDX_W-1:0] RTC_IDX = 8'h3F,
  parameter logic [IDX_W-1:0] HIDE_IDX = 8'h20,
  parameter logic [IDX_W-1:0] HIDE_BASE = 8'hC0
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  cfgStrobes_t                        stb,
  input  logic [IDX_W-1:0]                   curIdx,
  input  logic [BYTE_W-1:0]                  wdata,
  input  logic                               cpuAlt,
  input  logic [BYTE_W-1:0]                  rtcIdx,
  output logic [BYTE_W-1:0]                  rdata,
  output logic                               unlocked,
  output logic [(1<<IDX_W)*BYTE_W-1:0]       storeFlat
);
  localparam int NUM_REGS = 1 << IDX_W;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [BYTE_W-1:0] MASK  = maskOf(g);
    localparam logic [BYTE_W-1:0] FORCE = forceOf(g);
    localparam logic [BYTE_W-1:0] RSTV  = resetOf(g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= RSTV;
      else if (stb.regWrite && (curIdx == IDX_W'(g))) q <= (wdata & MASK) | FORCE;
    end
    assign storeFlat[g*BYTE_W +: BYTE_W] = q;
  end

  logic [IDX_W+2:0] bitBase;
  logic             hidden;

  assign bitBase  = {curIdx, 3'b000};
  assign hidden   = cpuAlt && ((curIdx == HIDE_IDX) || (curIdx >= HIDE_BASE));
  assign unlocked = (storeFlat[LOCK_IDX*BYTE_W +: BYTE_W] == UNLOCK_KEY);

  always_comb begin
    if (!stb.dataRead || hidden) rdata = 8'hFF;
    else if (curIdx == RTC_IDX)  rdata = rtcIdx;
    else                         rdata = storeFlat[bitBase +: BYTE_W];
  end

  // R4: index 0x21 always carries its forced bit after a write
  a_r4_force_21: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWrite && curIdx == 8'h21) |=> storeFlat['h21*8+2]);

  // R3: the masked-off bit of index 0x14 never becomes set
  a_r3_mask_14: assert property (@(posedge clk) disable iff (!rstN)
    !storeFlat['h14*8+6]);

  // R6: the RTC index byte is returned for its index
  a_r6_rtc_read: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataRead && !cpuAlt && curIdx == RTC_IDX) |-> (rdata == rtcIdx));
endmodule

// File: rtl/lockedCfgRegs.sv
module lockedCfgRegs
  import cfgPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0023,
  parameter logic [IDX_W-1:0] LOCK_IDX = 8'h03,
  parameter logic [7:0] UNLOCK_KEY = 8'hC5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              ioAddr,
  input  logic                           ioWr,
  input  logic                           ioRd,
  input  logic [7:0]                     ioWdata,
  output logic [7:0]                     ioRdata,
  input  logic                           cpuAlt,
  input  logic [7:0]                     rtcIdx,
  output logic [(1<<IDX_W)*8-1:0]        regFlat
);
  cfgStrobes_t     stb;
  logic [IDX_W-1:0] curIdx;
  logic            unlocked;

  cfgCtrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .INDEX_PORT(INDEX_PORT),
    .DATA_PORT(DATA_PORT), .LOCK_IDX(LOCK_IDX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .unlocked(unlocked), .curIdx(curIdx), .stb(stb)
  );

  cfgStore #(
    .IDX_W(IDX_W), .LOCK_IDX(LOCK_IDX), .UNLOCK_KEY(UNLOCK_KEY)
  ) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .curIdx(curIdx), .wdata(ioWdata),
    .cpuAlt(cpuAlt), .rtcIdx(rtcIdx), .rdata(ioRdata), .unlocked(unlocked),
    .storeFlat(regFlat)
  );

  // R2: a data write to a non-lock index while locked leaves every register unchanged
  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == DATA_PORT && curIdx != LOCK_IDX &&
     regFlat[LOCK_IDX*8 +: 8] != UNLOCK_KEY) |=> $stable(regFlat));

  // R5: hidden indices read as all ones for the alternate CPU type
  a_r5_cpu_hide: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr == DATA_PORT && cpuAlt && (curIdx == 8'h20 || curIdx >= 8'hC0))
      |-> (ioRdata == 8'hFF));

  // R8: no read strobe or another address gives all ones
  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rstN)
    (!ioRd || ioAddr != DATA_PORT) |-> (ioRdata == 8'hFF));
endmodule

// File: tb/sim_lockedCfgRegs.sv
module sim_lockedCfgRegs;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  ioAddr = '0;
  logic         ioWr = 1'b0;
  logic         ioRd = 1'b0;
  logic [7:0]   ioWdata = '0;
  logic [7:0]   ioRdata;
  logic         cpuAlt = 1'b0;
  logic [7:0]   rtcIdx = 8'h6D;
  logic [2047:0] regFlat;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lockedCfgRegs u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .cpuAlt(cpuAlt), .rtcIdx(rtcIdx),
    .regFlat(regFlat)
  );

  function automatic logic [7:0] bMask(input int i);
    case (i)
      'h14: return 8'hBF; 'h15: return 8'hF1; 'h1C: return 8'h1F;
      'h1E: return 8'h40; 'h22: return 8'hFD; 'h28: return 8'h3F;
      'h36: return 8'hE5; 'h37: return 8'hEF; 'h3D: return 8'h07;
      'h40: return 8'h3F; 'h21: return 8'hBB; 'h2B: return 8'hBF;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bForce(input int i);
    if (i == 'h21) return 8'h04;
    if (i == 'h2B) return 8'h40;
    return 8'h00;
  endfunction

  function automatic logic [7:0] bReset(input int i);
    case (i)
      'h02: return 8'h0F; 'h10: return 8'hF1; 'h11: return 8'hFF;
      'h15: return 8'h20; 'h16: return 8'h30; 'h19: return 8'h04;
      'h3C: return 8'h03; 'h3D: return 8'h01; 'h40: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(input int i);
    if (i == 'h21 || i == 'h2B) return "R4";
    if (bMask(i) != 8'hFF) return "R3";
    return "R9";
  endfunction

  task automatic check(input string tag, input int idx, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s idx=%02h actual=%02h expected=%02h", tag, idx, got, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #2 d = ioRdata;
    ioRd = 1'b0;
  endtask

  task automatic regWrite(input int i, input logic [7:0] d);
    ioWrite(16'h22, 8'(i));
    ioWrite(16'h23, d);
  endtask

  task automatic regRead(input int i, output logic [7:0] d);
    ioWrite(16'h22, 8'(i));
    ioRead(16'h23, d);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] exp;
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7: reset contents, on the vector and through the read path
    for (int i = 0; i < 256; i++) begin
      check("R7", i, regFlat[i*8 +: 8], bReset(i));
      if (i != 'h3F) begin
        regRead(i, rd);
        check("R7", i, rd, bReset(i));
      end
    end

    // R2: locked bank ignores writes to every non-lock index
    for (int i = 0; i < 256; i++) begin
      if (i == 3) continue;
      regWrite(i, 8'h5A);
      check("R2", i, regFlat[i*8 +: 8], bReset(i));
    end

    // R2: the lock register itself is always writable
    regWrite(3, 8'hC5);
    check("R2", 3, regFlat[3*8 +: 8], 8'hC5);

    // R1 R3 R4 R9 R6: write patterns through the masks, read back
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        if (i == 3) continue;
        v = (p == 3) ? 8'(i) : pats[p];
        exp = (v & bMask(i)) | bForce(i);
        regWrite(i, v);
        check(tagOf(i), i, regFlat[i*8 +: 8], exp);
        ioRead(16'h23, rd);
        if (i == 'h3F) check("R6", i, rd, rtcIdx);
        else check("R1", i, rd, exp);
      end
    end

    // R6: the external byte tracks its input
    rtcIdx = 8'h92;
    regRead('h3F, rd);
    check("R6", 'h3F, rd, 8'h92);

    // R5: hidden indices with the alternate CPU type
    cpuAlt = 1'b1;
    for (int i = 0; i < 256; i++) begin
      regRead(i, rd);
      if (i == 'h20 || i >= 'hC0) exp = 8'hFF;
      else if (i == 'h3F) exp = rtcIdx;
      else if (i == 3) exp = 8'hC5;
      else exp = (8'(i) & bMask(i)) | bForce(i);
      check("R5", i, rd, exp);
    end
    cpuAlt = 1'b0;
    regRead('h20, rd);
    check("R5", 'h20, rd, 8'h20);

    // R8: other ports and idle read strobe
    ioRead(16'h0022, rd); check("R8", 0, rd, 8'hFF);
    ioRead(16'h0024, rd); check("R8", 0, rd, 8'hFF);
    ioRead(16'h0123, rd); check("R8", 0, rd, 8'hFF);
    @(negedge clk); ioAddr = 16'h23; #2 check("R8", 0, ioRdata, 8'hFF);

    // R2: relocking blocks further writes
    regWrite(3, 8'h00);
    regWrite('h10, 8'h77);
    check("R2", 'h10, regFlat['h10*8 +: 8], 8'h10);
    regWrite(3, 8'hC4);
    regWrite('h10, 8'h77);
    check("R2", 'h10, regFlat['h10*8 +: 8], 8'h10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule